// File: doc/BRIEF.md
# VMEbus slave address window decoder

This block is the address front end of a bus slave on a graphics board. Each access cycle it looks at the bus address, the address-modifier code and the transfer size, and decides which of three windows, if any, the access falls in. The three windows are a small control register block, a 1 KB line buffer and a 64 MB memory window. For the selected window it produces a local offset. For data writes it also produces per-lane write enables. The storage behind the line buffer and the memory window sits outside this block.

The control register block lives in short (A16) space, at a 4 KB slot picked by four jumper inputs. The line buffer can be placed at any 1 KB boundary in short or standard (A24) space through a base register. The memory window is placed in extended (A32) space through a 6-bit base register. Both base registers live inside the control register block and are written over the bus. Byte writes to the control block are dropped, while byte reads still return the register contents. Decode is combinational on the access inputs. Register updates land on the clock edge that ends the access cycle.

Top module: `vme_window_decoder`

## Requirements
- R1: After reset, the line-buffer base register reads 0x0020 (A16 position 0x8000) and the memory-window base register reads 0x0028 (A32 position 0xA0000000).
- R2: Address-modifier codes 0x29/0x2D mean short space, 0x39/0x3D mean standard space and 0x09/0x0D mean extended space. Any other code selects nothing. The transfer size is encoded 0 = byte, 1 = 16-bit, 2 = 32-bit. Size code 3 selects nothing.
- R3: The control block is selected only for a short-space code with a nonzero jumper value equal to address bits 15..12. A jumper value of zero never selects it. Its offset is address bits 11..0.
- R4: The line buffer is selected in short space when address bits 15..10 equal base bits 5..0. It is also selected in standard space when address bits 23..10 equal all 14 base bits. Its offset is address bits 9..0.
- R5: The memory window is selected only for an extended-space code when address bits 31..26 equal the 6-bit base. Its offset is address bits 25..0.
- R6: At most one select is active. When the control block and the line buffer both match, the control block wins.
- R7: Control registers are indexed by address bits 11..2. Index 0 is the line-buffer base in data bits 13..0. Index 1 is the memory base in data bits 5..0. A 16-bit or 32-bit write takes its value from data bits 15..0 and shows from the next clock edge.
- R8: A byte write to the control block changes no register.
- R9: A read of the control block of any size returns the indexed register, zero-extended, on data bits 15..0. Indices other than 0 and 1 read zero. Bits 31..16 carry no defined value.
- R10: For writes to the line buffer or the memory window, lane enable bit 3 is data bits 31..24 (byte address 0) and bit 0 is data bits 7..0. A 32-bit write gives 1111. A 16-bit write gives 1100 when address bit 1 is 0 and 0011 when it is 1. A byte write gives 1000 shifted right by address bits 1..0. Reads, control-block writes and unselected accesses give 0000.
- R11: With the access strobe low, no select is active and the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| jumper_i | input | 4 | Control-block slot in short space |
| strobe_i | input | 1 | Access cycle valid |
| write_i | input | 1 | 1 = write, 0 = read |
| am_i | input | 6 | Address-modifier code |
| size_i | input | 2 | Transfer size code |
| addr_i | input | 32 | Bus address |
| wdata_i | input | 32 | Write data |
| sel_regs_o | output | 1 | Control block selected |
| sel_lbuf_o | output | 1 | Line buffer selected |
| sel_mem_o | output | 1 | Memory window selected |
| offset_o | output | 26 | Offset within the selected window |
| lane_we_o | output | 4 | Per-lane write enables for buffer and memory |
| rdata_o | output | 32 | Control-block read data |

## Verification
The bench builds the block with its default parameters: a 4-bit jumper, a 14-bit line-buffer base, a 1 KB buffer span and a 6-bit memory base on a 32-bit address. With these values the forbidden zero jumper, a jumper value equal to the line-buffer slot (to exercise priority), and standard-space buffer placement all fall inside a short run. Moving both base registers over the bus lets the bench confirm that later decode follows the new values. It also confirms that a dropped byte write leaves that decode unchanged.

// File: rtl/vwd_pkg.sv
`timescale 1ns/1ps
package vwd_pkg;

  typedef enum logic [1:0] {
    SZ_B8  = 2'b00,
    SZ_H16 = 2'b01,
    SZ_W32 = 2'b10,
    SZ_RSV = 2'b11
  } xfer_size_t;

  typedef enum logic [1:0] {
    SP_NONE  = 2'b00,
    SP_SHORT = 2'b01,
    SP_STD   = 2'b10,
    SP_EXT   = 2'b11
  } space_t;

  // Map an address-modifier code onto the address space it names.
  function automatic space_t classify_am(input logic [5:0] am);
    case (am)
      6'h29, 6'h2D: return SP_SHORT;
      6'h39, 6'h3D: return SP_STD;
      6'h09, 6'h0D: return SP_EXT;
      default:      return SP_NONE;
    endcase
  endfunction

  // Byte lanes touched by a transfer; bit 3 is the lane at byte address 0.
  function automatic logic [3:0] lane_mask(input xfer_size_t sz, input logic [1:0] a);
    case (sz)
      SZ_W32:  return 4'b1111;
      SZ_H16:  return a[1] ? 4'b0011 : 4'b1100;
      SZ_B8:   return 4'b1000 >> a;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/vwd_am_decode.sv
`timescale 1ns/1ps
module vwd_am_decode
  import vwd_pkg::*;
(
  input  logic [5:0] am,
  input  logic [1:0] size,
  input  logic       strobe,
  output space_t     space,
  output logic       access_ok
);
  always_comb begin
    space     = classify_am(am);
    access_ok = strobe && (xfer_size_t'(size) != SZ_RSV) && (space != SP_NONE);
  end
endmodule

// File: rtl/vwd_window_match.sv
`timescale 1ns/1ps
module vwd_window_match
  import vwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int JUMP_W  = 4,
  parameter int LB_W    = 14,
  parameter int LB_SPAN = 10,
  parameter int MB_W    = 6
) (
  input  logic [ADDR_W-1:0]        addr,
  input  space_t                   space,
  input  logic                     access_ok,
  input  logic [JUMP_W-1:0]        jumper,
  input  logic [LB_W-1:0]          lb_base,
  input  logic [MB_W-1:0]          mb_base,
  output logic                     hit_regs,
  output logic                     hit_lbuf,
  output logic                     hit_mem,
  output logic                     lbuf_shadowed,
  output logic [ADDR_W-MB_W-1:0]   offset
);
  localparam int SHORT_W   = 16;
  localparam int CSR_SPAN  = SHORT_W - JUMP_W;
  localparam int LB_SHORT  = SHORT_W - LB_SPAN;
  localparam int OFF_W     = ADDR_W - MB_W;

  logic jumper_forbidden;
  logic raw_regs, raw_lbuf_short, raw_lbuf_std, raw_lbuf;

  always_comb begin
    jumper_forbidden = (jumper == '0);
    raw_regs = access_ok && (space == SP_SHORT) && !jumper_forbidden &&
               (addr[SHORT_W-1:CSR_SPAN] == jumper);
    raw_lbuf_short = (space == SP_SHORT) &&
                     (addr[SHORT_W-1:LB_SPAN] == lb_base[LB_SHORT-1:0]);
    raw_lbuf_std   = (space == SP_STD) &&
                     (addr[LB_SPAN+LB_W-1:LB_SPAN] == lb_base);
    raw_lbuf = access_ok && (raw_lbuf_short || raw_lbuf_std);
    hit_regs = raw_regs;
    hit_lbuf = raw_lbuf && !raw_regs;
    lbuf_shadowed = raw_lbuf && raw_regs;
    hit_mem  = access_ok && (space == SP_EXT) && (addr[ADDR_W-1:OFF_W] == mb_base);
  end

  always_comb begin
    if (hit_regs)
      offset = {{(OFF_W-CSR_SPAN){1'b0}}, addr[CSR_SPAN-1:0]};
    else if (hit_lbuf)
      offset = {{(OFF_W-LB_SPAN){1'b0}}, addr[LB_SPAN-1:0]};
    else if (hit_mem)
      offset = addr[OFF_W-1:0];
    else
      offset = '0;
  end
endmodule

// File: rtl/vwd_csr_regs.sv
`timescale 1ns/1ps
module vwd_csr_regs #(
  parameter int              LB_W     = 14,
  parameter int              MB_W     = 6,
  parameter int              IDX_W    = 10,
  parameter logic [LB_W-1:0] LB_RESET = 'h20,
  parameter logic [MB_W-1:0] MB_RESET = 'h28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [LB_W-1:0]  lb_wdata,
  input  logic [MB_W-1:0]  mb_wdata,
  output logic [LB_W-1:0]  lb_base,
  output logic [MB_W-1:0]  mb_base,
  output logic [15:0]      rd16
);
  localparam logic [IDX_W-1:0] IDX_LB = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_MB = IDX_W'(1);

  logic wr_lb, wr_mb;
  assign wr_lb = wr_en && (idx == IDX_LB);
  assign wr_mb = wr_en && (idx == IDX_MB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_base <= LB_RESET;
      mb_base <= MB_RESET;
    end else begin
      if (wr_lb) lb_base <= lb_wdata;
      if (wr_mb) mb_base <= mb_wdata;
    end
  end

  always_comb begin
    case (idx)
      IDX_LB:  rd16 = {{(16-LB_W){1'b0}}, lb_base};
      IDX_MB:  rd16 = {{(16-MB_W){1'b0}}, mb_base};
      default: rd16 = 16'h0000;
    endcase
  end
endmodule

// File: rtl/vme_window_decoder.sv
`timescale 1ns/1ps
module vme_window_decoder
  import vwd_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              JUMP_W   = 4,
  parameter int              LB_W     = 14,
  parameter int              LB_SPAN  = 10,
  parameter int              MB_W     = 6,
  parameter logic [LB_W-1:0] LB_RESET = 'h20,
  parameter logic [MB_W-1:0] MB_RESET = 'h28
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [JUMP_W-1:0]      jumper_i,
  input  logic                   strobe_i,
  input  logic                   write_i,
  input  logic [5:0]             am_i,
  input  logic [1:0]             size_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic                   sel_regs_o,
  output logic                   sel_lbuf_o,
  output logic                   sel_mem_o,
  output logic [ADDR_W-MB_W-1:0] offset_o,
  output logic [3:0]             lane_we_o,
  output logic [31:0]            rdata_o
);
  localparam int SHORT_W  = 16;
  localparam int CSR_SPAN = SHORT_W - JUMP_W;
  localparam int IDX_W    = CSR_SPAN - 2;
  localparam int DATA_W   = 32;

  space_t           space;
  logic             access_ok;
  logic             hit_regs, hit_lbuf, hit_mem, lbuf_shadowed;
  logic [LB_W-1:0]  lb_base;
  logic [MB_W-1:0]  mb_base;
  logic [15:0]      rd16;
  logic             csr_write_ok, csr_byte_drop, data_write;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:LB_W];

  vwd_am_decode u_am (
    .am        (am_i),
    .size      (size_i),
    .strobe    (strobe_i),
    .space     (space),
    .access_ok (access_ok)
  );

  vwd_window_match #(
    .ADDR_W (ADDR_W), .JUMP_W (JUMP_W), .LB_W (LB_W),
    .LB_SPAN(LB_SPAN), .MB_W (MB_W)
  ) u_match (
    .addr          (addr_i),
    .space         (space),
    .access_ok     (access_ok),
    .jumper        (jumper_i),
    .lb_base       (lb_base),
    .mb_base       (mb_base),
    .hit_regs      (hit_regs),
    .hit_lbuf      (hit_lbuf),
    .hit_mem       (hit_mem),
    .lbuf_shadowed (lbuf_shadowed),
    .offset        (offset_o)
  );

  // Control-block write events, named so the checker can see them.
  assign csr_write_ok  = hit_regs && write_i && (xfer_size_t'(size_i) != SZ_B8);
  assign csr_byte_drop = hit_regs && write_i && (xfer_size_t'(size_i) == SZ_B8);
  assign data_write    = write_i && (hit_lbuf || hit_mem);

  vwd_csr_regs #(
    .LB_W (LB_W), .MB_W (MB_W), .IDX_W (IDX_W),
    .LB_RESET (LB_RESET), .MB_RESET (MB_RESET)
  ) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (csr_write_ok),
    .idx      (addr_i[CSR_SPAN-1:2]),
    .lb_wdata (wdata_i[LB_W-1:0]),
    .mb_wdata (wdata_i[MB_W-1:0]),
    .lb_base  (lb_base),
    .mb_base  (mb_base),
    .rd16     (rd16)
  );

  assign sel_regs_o = hit_regs;
  assign sel_lbuf_o = hit_lbuf;
  assign sel_mem_o  = hit_mem;
  assign lane_we_o  = data_write ? lane_mask(xfer_size_t'(size_i), addr_i[1:0]) : 4'b0000;
  // Upper half of a control-block read is undefined; it mirrors the low half.
  assign rdata_o    = {rd16, rd16};
endmodule

// File: rtl/vwd_checker.sv
`timescale 1ns/1ps
module vwd_checker #(
  parameter int JUMP_W = 4,
  parameter int LB_W   = 14,
  parameter int MB_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_i,
  input logic              write_i,
  input logic [5:0]        am_i,
  input logic [JUMP_W-1:0] jumper_i,
  input logic              sel_regs_o,
  input logic              sel_lbuf_o,
  input logic              sel_mem_o,
  input logic [3:0]        lane_we_o,
  input logic              csr_byte_drop,
  input logic              lbuf_shadowed,
  input logic [LB_W-1:0]   lb_base,
  input logic [MB_W-1:0]   mb_base
);
  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_regs_o, sel_lbuf_o, sel_mem_o}));

  assert_shadow_yields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lbuf_shadowed |-> (sel_regs_o && !sel_lbuf_o));

  assert_regs_placement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_regs_o |-> ((jumper_i != '0) && (am_i == 6'h29 || am_i == 6'h2D)));

  assert_mem_extended_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_mem_o |-> (am_i == 6'h09 || am_i == 6'h0D));

  assert_byte_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_byte_drop |=> ($stable(lb_base) && $stable(mb_base)));

  assert_lane_we_data_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we_o != 4'b0000) |-> (write_i && (sel_lbuf_o || sel_mem_o)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |-> !(sel_regs_o || sel_lbuf_o || sel_mem_o));
endmodule

bind vme_window_decoder vwd_checker #(
  .JUMP_W (JUMP_W), .LB_W (LB_W), .MB_W (MB_W)
) u_vwd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .strobe_i      (strobe_i),
  .write_i       (write_i),
  .am_i          (am_i),
  .jumper_i      (jumper_i),
  .sel_regs_o    (sel_regs_o),
  .sel_lbuf_o    (sel_lbuf_o),
  .sel_mem_o     (sel_mem_o),
  .lane_we_o     (lane_we_o),
  .csr_byte_drop (csr_byte_drop),
  .lbuf_shadowed (lbuf_shadowed),
  .lb_base       (lb_base),
  .mb_base       (mb_base)
);

// File: tb/vme_window_decoder_test.sv
`timescale 1ns/1ps
module vme_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  jumper = 4'hC;
  logic        strobe = 1'b0;
  logic        write = 1'b0;
  logic [5:0]  am = 6'h00;
  logic [1:0]  size = 2'b00;
  logic [31:0] addr = 32'h0;
  logic [31:0] wdata = 32'h0;
  logic        sel_regs, sel_lbuf, sel_mem;
  logic [25:0] offset;
  logic [3:0]  lane_we;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vme_window_decoder uut (
    .clk (clk), .rst_n (rst_n), .jumper_i (jumper), .strobe_i (strobe),
    .write_i (write), .am_i (am), .size_i (size), .addr_i (addr),
    .wdata_i (wdata), .sel_regs_o (sel_regs), .sel_lbuf_o (sel_lbuf),
    .sel_mem_o (sel_mem), .offset_o (offset), .lane_we_o (lane_we),
    .rdata_o (rdata)
  );

  typedef struct {
    logic [2:0]  sel;
    logic [25:0] off;
    logic [3:0]  we;
    logic [15:0] rd;
    bit          chk_rd;
    string       tag;
  } item_t;

  item_t exp_q[$];

  // Bench-side register image, updated from the requirements alone.
  logic [13:0] m_lb = 14'h0020;
  logic [5:0]  m_mb = 6'h28;

  function automatic item_t predict(input bit stb, input bit wr, input logic [5:0] c,
                                    input logic [1:0] sz, input logic [31:0] a,
                                    input logic [3:0] jp, input string tag);
    item_t it;
    bit sh, sd, ex, ok, r, l, m;
    logic [9:0] idx;
    sh = (c == 6'h29) || (c == 6'h2D);
    sd = (c == 6'h39) || (c == 6'h3D);
    ex = (c == 6'h09) || (c == 6'h0D);
    ok = stb && (sz != 2'd3);
    r  = ok && sh && (jp != 4'h0) && (a[15:12] == jp);
    l  = ok && !r && ((sh && a[15:10] == m_lb[5:0]) || (sd && a[23:10] == m_lb));
    m  = ok && ex && (a[31:26] == m_mb);
    it.sel = {r, l, m};
    it.off = r ? {14'h0, a[11:0]} : l ? {16'h0, a[9:0]} : m ? a[25:0] : 26'h0;
    it.we  = 4'b0000;
    if (wr && (l || m)) begin
      if (sz == 2'd2)      it.we = 4'b1111;
      else if (sz == 2'd1) it.we = a[1] ? 4'b0011 : 4'b1100;
      else                 it.we = 4'b1000 >> a[1:0];
    end
    idx = a[11:2];
    it.chk_rd = r && !wr;
    it.rd = (idx == 10'd0) ? {2'b00, m_lb} : (idx == 10'd1) ? {10'h0, m_mb} : 16'h0;
    it.tag = tag;
    return it;
  endfunction

  task automatic access(input bit stb, input bit wr, input logic [5:0] c,
                        input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] jp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    strobe = stb; write = wr; am = c; size = sz; addr = a; wdata = d; jumper = jp;
    it = predict(stb, wr, c, sz, a, jp, tag);
    exp_q.push_back(it);
    if (it.sel[2] && wr && sz != 2'd0) begin
      if (a[11:2] == 10'd0) m_lb = d[13:0];
      else if (a[11:2] == 10'd1) m_mb = d[5:0];
    end
  endtask

  // Monitor: compares the settled outputs at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      checks++;
      if ({sel_regs, sel_lbuf, sel_mem} !== e.sel || offset !== e.off ||
          lane_we !== e.we || (e.chk_rd && rdata[15:0] !== e.rd)) begin
        errors++;
        $display("FAIL %s: sel=%b off=%h we=%b rd=%h expected sel=%b off=%h we=%b rd=%h",
                 e.tag, {sel_regs, sel_lbuf, sel_mem}, offset, lane_we, rdata[15:0],
                 e.sel, e.off, e.we, e.rd);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values read back over the bus
    access(1, 0, 6'h29, 2'd1, 32'h0000C000, 0, 4'hC, "R1 lbuf base reset");
    access(1, 0, 6'h29, 2'd1, 32'h0000C004, 0, 4'hC, "R1 mem base reset");
    // R9: byte and 32-bit reads, unused index
    access(1, 0, 6'h2D, 2'd0, 32'h0000C001, 0, 4'hC, "R9 byte read");
    access(1, 0, 6'h29, 2'd2, 32'h0000C004, 0, 4'hC, "R9 word read");
    access(1, 0, 6'h29, 2'd1, 32'h0000C010, 0, 4'hC, "R9 unused index");
    // R3: placement, offsets, forbidden jumper
    access(1, 0, 6'h29, 2'd1, 32'h0000CABC, 0, 4'hC, "R3 regs offset");
    access(1, 0, 6'h39, 2'd1, 32'h0000C000, 0, 4'hC, "R3 std space no regs");
    access(1, 0, 6'h29, 2'd1, 32'h00000010, 0, 4'h0, "R3 jumper zero");
    access(1, 0, 6'h29, 2'd1, 32'h00005004, 0, 4'h5, "R3 other jumper");
    // R4: line buffer in both spaces
    access(1, 0, 6'h29, 2'd1, 32'h00008000, 0, 4'hC, "R4 short low edge");
    access(1, 0, 6'h2D, 2'd1, 32'h000083FE, 0, 4'hC, "R4 short high edge");
    access(1, 0, 6'h29, 2'd1, 32'h00008400, 0, 4'hC, "R4 past end");
    access(1, 0, 6'h3D, 2'd1, 32'h00008123, 0, 4'hC, "R4 std space");
    access(1, 0, 6'h39, 2'd1, 32'h00018000, 0, 4'hC, "R4 std high bits differ");
    // R5: memory window
    access(1, 0, 6'h09, 2'd2, 32'hA1234567, 0, 4'hC, "R5 mem hit");
    access(1, 0, 6'h0D, 2'd2, 32'hA4000000, 0, 4'hC, "R5 mem miss");
    access(1, 0, 6'h09, 2'd1, 32'h0000C000, 0, 4'hC, "R5 ext code on regs addr");
    // R2: unknown code and reserved size
    access(1, 0, 6'h3F, 2'd1, 32'h0000C000, 0, 4'hC, "R2 unknown code");
    access(1, 0, 6'h29, 2'd3, 32'h0000C000, 0, 4'hC, "R2 reserved size");
    // R11: idle
    access(0, 0, 6'h29, 2'd1, 32'h0000C000, 0, 4'hC, "R11 idle");
    // R8: byte write dropped, then read back
    access(1, 1, 6'h29, 2'd0, 32'h0000C001, 32'h55555555, 4'hC, "R8 byte write");
    access(1, 0, 6'h29, 2'd1, 32'h0000C000, 0, 4'hC, "R8 lbuf unchanged");
    access(1, 0, 6'h29, 2'd0, 32'h00008000, 0, 4'hC, "R8 decode unchanged");
    // R7: 16-bit write of line-buffer base onto the regs slot
    access(1, 1, 6'h29, 2'd1, 32'h0000C000, 32'h00000030, 4'hC, "R7 lbuf write");
    access(1, 0, 6'h29, 2'd1, 32'h0000C000, 0, 4'hC, "R7 lbuf readback");
    access(1, 0, 6'h29, 2'd1, 32'h0000C200, 0, 4'hC, "R6 regs over lbuf");
    access(1, 0, 6'h39, 2'd1, 32'h0000C010, 0, 4'hC, "R7 lbuf moved std");
    access(1, 0, 6'h29, 2'd1, 32'h00008000, 0, 4'hC, "R7 old slot free");
    // R7: 32-bit write of memory base
    access(1, 1, 6'h29, 2'd2, 32'h0000C004, 32'hFFFF0011, 4'hC, "R7 mem write");
    access(1, 0, 6'h29, 2'd2, 32'h0000C004, 0, 4'hC, "R7 mem readback");
    access(1, 0, 6'h09, 2'd1, 32'h44000100, 0, 4'hC, "R7 mem moved");
    access(1, 0, 6'h09, 2'd1, 32'hA0000000, 0, 4'hC, "R7 old mem free");
    // R6: jumper coinciding with lbuf slot, restore lbuf base first
    access(1, 1, 6'h29, 2'd1, 32'h0000C000, 32'h00000020, 4'hC, "R7 lbuf restore");
    access(1, 0, 6'h29, 2'd1, 32'h00008004, 0, 4'h8, "R6 priority jumper 8");
    access(1, 0, 6'h29, 2'd1, 32'h00008004, 0, 4'hC, "R6 lbuf without overlap");
    // R10: lane enables
    access(1, 1, 6'h39, 2'd0, 32'h00008003, 32'h12, 4'hC, "R10 byte lane 3");
    access(1, 1, 6'h39, 2'd0, 32'h00008000, 32'h12, 4'hC, "R10 byte lane 0");
    access(1, 1, 6'h29, 2'd1, 32'h00008000, 32'h1234, 4'hC, "R10 half low addr");
    access(1, 1, 6'h29, 2'd1, 32'h00008002, 32'h1234, 4'hC, "R10 half high addr");
    access(1, 1, 6'h09, 2'd2, 32'h44000008, 32'hDEADBEEF, 4'hC, "R10 mem word");
    access(1, 1, 6'h09, 2'd2, 32'h48000008, 32'hDEADBEEF, 4'hC, "R10 mem miss no we");
    access(1, 1, 6'h29, 2'd1, 32'h0000C010, 32'h1, 4'hC, "R10 regs write no we");
    access(1, 0, 6'h09, 2'd2, 32'h44000008, 0, 4'hC, "R10 read no we");
    access(0, 0, 6'h00, 2'd0, 32'h0, 0, 4'hC, "R11 final idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule